// File: doc/BRIEF.md
# Saturating ECC Error Count Register

This block tracks memory read-response integrity for two pseudo-channels. Each channel has two saturating counters. One counts correctable single-bit errors and the other counts uncorrectable double-bit errors. An upstream ECC checker feeds them one pulse per error per cycle. Software reads each channel's counters as one 32-bit word at a fixed bus offset. It resets a count by writing ones into that count's field.

A counter stops at full scale and does not wrap. When another error arrives while the counter is full, a sticky overflow flag is set. Each flag appears on its own status output and is cleared together with its count. Bus reads are registered, so the data appears one cycle after the read strobe.

Top module: `ecc_err_stat`

## Requirements
- R1: The single-bit error count of a channel reads in word bits [CNT_W-1:0]. It increases by one in each cycle in which that channel's single-bit pulse is high.
- R2: The double-bit error count of a channel reads in word bits [16+CNT_W-1:16]. It increases by one in each cycle in which that channel's double-bit pulse is high.
- R3: Bits 15 and 31 of every returned word read as zero. So does any field bit above CNT_W.
- R4: After a synchronous reset, every count, every overflow flag and the read data are zero.
- R5: A count that has reached 2^CNT_W-1 stays there when further errors arrive.
- R6: An error that arrives while its count is at 2^CNT_W-1 sets that counter's sticky overflow output (sbe_ovf[ch] or dbe_ovf[ch]). The flag stays set until that field is cleared.
- R7: A write with any 1 in bits 14:0 clears the single-bit count and its overflow flag. A write with any 1 in bits 30:16 does the same for the double-bit count and its flag. Zeros leave a field unchanged.
- R8: When a clearing write and an error pulse hit the same field in the same cycle, the field ends at zero with its flag low.
- R9: Single-bit and double-bit pulses in the same cycle each advance their own count. The two channels never affect each other.
- R10: Channel 0 is mapped at CH0_ADDR (0x0560) and channel 1 at CH1_ADDR (0x0860). bus_rdata shows the addressed word one cycle after bus_rd, holding the values from before that edge. It is zero in any cycle that follows no read.
- R11: A read of an address that maps to neither channel returns zero. A write to such an address changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sbe_pulse | input | 2 | Per-channel correctable error pulse |
| dbe_pulse | input | 2 | Per-channel uncorrectable error pulse |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data (ones clear fields) |
| bus_rdata | output | 32 | Registered read data |
| sbe_ovf | output | 2 | Per-channel single-bit overflow flags |
| dbe_ovf | output | 2 | Per-channel double-bit overflow flags |

## Verification
The bench builds the block with CNT_W set to 4, so full scale is 15. Saturation, overflow, and overflow followed by clearing can then be reached in a few dozen pulses rather than 32767. The address parameters keep their default offsets, which exercises the real decode of both channels and of the unmapped neighbours.

// File: rtl/ecc_stat_pkg.sv
package ecc_stat_pkg;

    localparam int WORD_W  = 32;
    localparam int FIELD_W = 15;

    typedef struct packed {
        logic               rsv_hi;
        logic [FIELD_W-1:0] dbl;
        logic               rsv_lo;
        logic [FIELD_W-1:0] sgl;
    } stat_word_t;

    typedef struct packed {
        logic sgl;
        logic dbl;
    } clr_req_t;

    function automatic clr_req_t decode_clear(input logic [WORD_W-1:0] wd);
        clr_req_t r;
        r.sgl = |wd[FIELD_W-1:0];
        r.dbl = |wd[FIELD_W+FIELD_W:FIELD_W+1];
        return r;
    endfunction

endpackage

// File: rtl/ecc_sat_cnt.sv
module ecc_sat_cnt #(
    parameter int W = 15
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    input  logic         clr,
    output logic [W-1:0] count,
    output logic         ovf
);
    localparam logic [W-1:0] FULL = {W{1'b1}};

    logic at_full;
    assign at_full = (count == FULL);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count <= '0;
            ovf   <= 1'b0;
        end else if (inc) begin
            if (at_full) ovf   <= 1'b1;
            else         count <= count + 1'b1;
        end
    end

    AST_SAT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (at_full && !clr) |=> (count == FULL));                              // R5
    AST_OVF_ON_FULL: assert property (@(posedge clk) disable iff (rst)
        (at_full && inc && !clr) |=> ovf);                                   // R6
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        (ovf && !clr) |=> ovf);                                              // R6
    AST_CLR_WINS: assert property (@(posedge clk) disable iff (rst)
        clr |=> (count == '0 && !ovf));                                      // R8
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        (inc && !at_full && !clr) |=> (count == $past(count) + 1'b1));       // R1
endmodule

// File: rtl/ecc_chan.sv
module ecc_chan
    import ecc_stat_pkg::*;
#(
    parameter int W = 15
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sgl_err,
    input  logic       dbl_err,
    input  clr_req_t   clr,
    output stat_word_t word,
    output logic       sgl_ovf,
    output logic       dbl_ovf
);
    logic [W-1:0] sgl_cnt, dbl_cnt;

    ecc_sat_cnt #(.W(W)) u_sgl (
        .clk(clk), .rst(rst), .inc(sgl_err), .clr(clr.sgl),
        .count(sgl_cnt), .ovf(sgl_ovf)
    );

    ecc_sat_cnt #(.W(W)) u_dbl (
        .clk(clk), .rst(rst), .inc(dbl_err), .clr(clr.dbl),
        .count(dbl_cnt), .ovf(dbl_ovf)
    );

    always_comb begin
        word        = '0;
        word.sgl    = FIELD_W'(sgl_cnt);
        word.dbl    = FIELD_W'(dbl_cnt);
    end
endmodule

// File: rtl/ecc_err_stat.sv
module ecc_err_stat
    import ecc_stat_pkg::*;
#(
    parameter int              CNT_W    = 15,
    parameter int              ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] CH0_ADDR = 16'h0560,
    parameter logic [ADDR_W-1:0] CH1_ADDR = 16'h0860
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        sbe_pulse,
    input  logic [1:0]        dbe_pulse,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [1:0]        sbe_ovf,
    output logic [1:0]        dbe_ovf
);
    localparam int NCH = 2;

    stat_word_t        words [NCH];
    logic [NCH-1:0]    hit;
    clr_req_t          wr_clr;
    logic              unused_rsv;

    assign wr_clr     = decode_clear(bus_wdata);
    assign unused_rsv = ^{bus_wdata[15], bus_wdata[31]};

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        localparam logic [ADDR_W-1:0] BASE = (ch == 0) ? CH0_ADDR : CH1_ADDR;
        clr_req_t ch_clr;

        assign hit[ch]    = (bus_addr == BASE);
        assign ch_clr.sgl = bus_wr && hit[ch] && wr_clr.sgl;
        assign ch_clr.dbl = bus_wr && hit[ch] && wr_clr.dbl;

        ecc_chan #(.W(CNT_W)) u_chan (
            .clk(clk), .rst(rst),
            .sgl_err(sbe_pulse[ch]), .dbl_err(dbe_pulse[ch]),
            .clr(ch_clr), .word(words[ch]),
            .sgl_ovf(sbe_ovf[ch]), .dbl_ovf(dbe_ovf[ch])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else begin
            bus_rdata <= '0;
            if (bus_rd) begin
                for (int i = 0; i < NCH; i++)
                    if (hit[i]) bus_rdata <= words[i];
            end
        end
    end

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_rdata[15] == 1'b0 && bus_rdata[31] == 1'b0));                   // R3
    AST_UNMAPPED_READ: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && hit == '0) |=> (bus_rdata == '0));                        // R11
    AST_IDLE_RDATA: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> (bus_rdata == '0));                                      // R10
    AST_SINGLE_HIT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit));                                                      // R10
endmodule

// File: tb/tb_ecc_err_stat.sv
module tb_ecc_err_stat;
    localparam int CNT_W = 4;
    localparam int FULL  = (1 << CNT_W) - 1;
    localparam logic [15:0] A0 = 16'h0560;
    localparam logic [15:0] A1 = 16'h0860;
    localparam logic [15:0] AX = 16'h0564;

    logic        clk = 0, rst = 1;
    logic [1:0]  sbe_pulse = 0, dbe_pulse = 0;
    logic [15:0] bus_addr = 0;
    logic        bus_rd = 0, bus_wr = 0;
    logic [31:0] bus_wdata = 0;
    logic [31:0] bus_rdata;
    logic [1:0]  sbe_ovf, dbe_ovf;

    int checks = 0, fails = 0;
    bit started = 0, done = 0;

    int  m_sc[2], m_dc[2];
    bit  m_so[2], m_do[2];
    logic [31:0] m_rd;

    always #10 clk = ~clk;

    ecc_err_stat #(.CNT_W(CNT_W), .ADDR_W(16), .CH0_ADDR(A0), .CH1_ADDR(A1)) dut (
        .clk(clk), .rst(rst), .sbe_pulse(sbe_pulse), .dbe_pulse(dbe_pulse),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sbe_ovf(sbe_ovf), .dbe_ovf(dbe_ovf)
    );

    function automatic logic [31:0] model_word(input logic [15:0] a);
        if (a == A0) return 32'((m_dc[0] << 16) | m_sc[0]);
        if (a == A1) return 32'((m_dc[1] << 16) | m_sc[1]);
        return 32'h0;
    endfunction

    // Behavioural reference, advanced on every rising edge
    always @(posedge clk) begin
        started = 1;
        if (rst) begin
            for (int c = 0; c < 2; c++) begin
                m_sc[c] = 0; m_dc[c] = 0; m_so[c] = 0; m_do[c] = 0;
            end
            m_rd = 0;
        end else begin
            m_rd = bus_rd ? model_word(bus_addr) : 32'h0;
            for (int c = 0; c < 2; c++) begin
                logic [15:0] a;
                a = (c == 0) ? A0 : A1;
                if (bus_wr && bus_addr == a && |bus_wdata[14:0]) begin
                    m_sc[c] = 0; m_so[c] = 0;
                end else if (sbe_pulse[c]) begin
                    if (m_sc[c] == FULL) m_so[c] = 1; else m_sc[c]++;
                end
                if (bus_wr && bus_addr == a && |bus_wdata[30:16]) begin
                    m_dc[c] = 0; m_do[c] = 0;
                end else if (dbe_pulse[c]) begin
                    if (m_dc[c] == FULL) m_do[c] = 1; else m_dc[c]++;
                end
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (started && !done) begin
            check("R10 rdata vs model", bus_rdata, m_rd);
            check("R6 sbe_ovf vs model", {30'h0, sbe_ovf}, {30'h0, m_so[1], m_so[0]});
            check("R6 dbe_ovf vs model", {30'h0, dbe_ovf}, {30'h0, m_do[1], m_do[0]});
        end
    end

    task automatic pulses(input logic [1:0] s, input logic [1:0] d, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); sbe_pulse = s; dbe_pulse = d;
        end
        @(negedge clk); sbe_pulse = 0; dbe_pulse = 0;
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk); bus_addr = a; bus_wr = 1; bus_wdata = d;
        @(negedge clk); bus_wr = 0; bus_wdata = 0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [31:0] d);
        @(negedge clk); bus_addr = a; bus_rd = 1;
        @(negedge clk); bus_rd = 0; d = bus_rdata;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 0;
        check("R4 reset ovf", {28'h0, sbe_ovf, dbe_ovf}, 32'h0);
        rd(A0, v); check("R4 reset ch0 word", v, 32'h0);
        rd(A1, v); check("R4 reset ch1 word", v, 32'h0);

        pulses(2'b01, 2'b00, 3);
        rd(A0, v); check("R1 single count", v, 32'h0000_0003);
        pulses(2'b00, 2'b01, 2);
        rd(A0, v); check("R2 double count", v, 32'h0002_0003);

        pulses(2'b10, 2'b10, 5);
        rd(A1, v); check("R9 simultaneous ch1", v, 32'h0005_0005);
        rd(A0, v); check("R9 ch0 untouched", v, 32'h0002_0003);

        wr(A0, 32'h0000_8000);
        rd(A0, v); check("R7 zero/reserved write no effect", v, 32'h0002_0003);
        wr(A0, 32'h0000_0400);
        rd(A0, v); check("R7 clear single only", v, 32'h0002_0000);

        pulses(2'b01, 2'b00, 20);
        rd(A0, v); check("R5 single saturates", v, 32'h0002_000F);
        check("R3 reserved and upper bits zero", v & 32'h8000_FFF0, 32'h0);
        check("R6 single overflow set", {31'h0, sbe_ovf[0]}, 32'h1);
        pulses(2'b00, 2'b00, 3);
        check("R6 overflow sticky", {31'h0, sbe_ovf[0]}, 32'h1);

        wr(AX, 32'hFFFF_FFFF);
        rd(A0, v); check("R11 unmapped write ignored", v, 32'h0002_000F);
        rd(AX, v); check("R11 unmapped read zero", v, 32'h0);

        @(negedge clk); bus_addr = A0; bus_wr = 1; bus_wdata = 32'h0000_0001; sbe_pulse = 2'b01;
        @(negedge clk); bus_wr = 0; bus_wdata = 0; sbe_pulse = 0;
        rd(A0, v); check("R8 clear beats pulse", v, 32'h0002_0000);
        check("R8 ovf cleared", {31'h0, sbe_ovf[0]}, 32'h0);

        wr(A1, 32'h0001_0000);
        rd(A1, v); check("R7 clear double ch1", v, 32'h0000_0005);
        pulses(2'b00, 2'b10, 17);
        rd(A1, v); check("R5 double saturates", v, 32'h000F_0005);
        check("R6 double overflow ch1", {31'h0, dbe_ovf[1]}, 32'h1);
        check("R9 ch0 double ovf clear", {31'h0, dbe_ovf[0]}, 32'h0);

        @(negedge clk);
        check("R10 idle rdata zero", bus_rdata, 32'h0);

        @(negedge clk); bus_addr = A1; bus_rd = 1; bus_wr = 1; bus_wdata = 32'hFFFF_FFFF;
        @(negedge clk); bus_rd = 0; bus_wr = 0; bus_wdata = 0;
        check("R10 read returns pre-clear value", bus_rdata, 32'h000F_0005);
        rd(A1, v); check("R7 full clear ch1", v, 32'h0);
        check("R7 ch1 flags cleared", {30'h0, sbe_ovf[1], dbe_ovf[1]}, 32'h0);

        repeat (2) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule